// File: doc/BRIEF.md
# Zero-Substitution Line Encoder (three-zero / four-zero)

This block turns a transmit bit stream into a dual-rail alternate-mark-inversion (AMI) line signal with zero substitution. One pair of line outputs carries the result: `line_pos` high means a positive mark and `line_neg` high means a negative mark. A single mode input selects the substitution length. When it is high, every run of three zeros is replaced. When it is low, every run of four zeros is replaced. The substituted pattern is chosen so that the number of ordinary alternating marks between two successive violation marks is always odd.

The encoder holds a short look-ahead shift register. A complete zero run is therefore recognised while its first bit is still inside the block. Two further paths share the same output register. The first is a pass-through for rails that are already encoded. The second is a loopback path that puts received dual-rail data on the line. A transmit-all-ones request overrides the bypass, and loopback overrides the all-ones request. The whole block runs on one clock, and all inputs are sampled on its rising edge. Mode and control inputs are expected to stay static while traffic flows.

Top module: `zs_line_encoder`

## Requirements
- R1: After synchronous reset both line outputs are low, and the first mark the encoder emits is positive, because the last-mark polarity resets to negative.
- R2: In encoder mode, data marks that are not part of a substitution alternate in polarity, and the two rails are never high together.
- R3: With `sel_b3zs`=1, each run of three zeros becomes B0V when the count of marks since the last violation is even, and 00V when it is odd. B takes the polarity opposite the previous mark. V takes the same polarity as the previous mark.
- R4: With `sel_b3zs`=0, each run of four zeros becomes B00V when that count is even and 000V when it is odd, with the same polarity rules as R3.
- R5: The mark count restarts at zero after every V, and a B counts as a mark. Zero runs are taken greedily from the first zero, with no overlap.
- R6: A data bit sampled at clock edge k appears on the line at edge k+4 in three-zero mode and at edge k+5 in four-zero mode.
- R7: With `enc_bypass`=1 (and no higher-priority request), the line outputs copy `tx_pos`/`tx_neg` two edges later, with no substitution.
- R8: With `all_ones`=1 and `remote_loop`=0, the line carries a mark on every cycle, alternating in polarity, one edge after sampling. The transmit data and `enc_bypass` have no effect.
- R9: With `remote_loop`=1, the line outputs copy `rx_pos`/`rx_neg` two edges later. Both the transmit data and `all_ones` are ignored.
- R10: In encoder mode the data bit is the OR of `tx_pos` and `tx_neg`. A mark given on either rail or on both gives the same line result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_b3zs | input | 1 | 1: three-zero substitution; 0: four-zero substitution |
| enc_bypass | input | 1 | 1: pass transmit rails to the line unencoded |
| all_ones | input | 1 | 1: send continuous alternating marks |
| remote_loop | input | 1 | 1: send received rails to the line |
| tx_pos | input | 1 | Transmit positive rail / binary data |
| tx_neg | input | 1 | Transmit negative rail / binary data |
| rx_pos | input | 1 | Received positive rail for loopback |
| rx_neg | input | 1 | Received negative rail for loopback |
| line_pos | output | 1 | Positive mark to the line |
| line_neg | output | 1 | Negative mark to the line |

## Verification
The hard case is a zero run that ends right where the mark-count parity flips. Examples are a run that starts just after a violation, or back-to-back runs in which each V sets up the next choice between B and plain zero. Such runs occur only when long zero stretches land at chosen distances from earlier marks. The stimulus therefore mixes sparse random data (mostly zeros), fully zero stretches, a single mark followed by zeros, and dense marks, in both modes. Each stream is compared against a greedy reference model that the bench computes from the whole sequence.

// File: rtl/zs_pkg.sv
// Shared types for the zero-substitution line encoder.
// Symbol kinds travel through the look-ahead register; the output
// selector names which source drives the line register.
package zs_pkg;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,   // plain zero
        SYM_MARK  = 2'd1,   // data one, follows alternation
        SYM_SUBST = 2'd2,   // first slot of a substituted run (B or zero)
        SYM_VIOL  = 2'd3    // violation slot closing a substituted run
    } sym_t;

    typedef enum logic [1:0] {
        OUT_ENC  = 2'd0,
        OUT_RAW  = 2'd1,
        OUT_ONES = 2'd2,
        OUT_LOOP = 2'd3
    } out_sel_t;

endpackage

// File: rtl/zs_lookahead.sv
// Zero-run detector and look-ahead shift register.
// Counts consecutive zeros at the input; when a run reaches the
// selected length it tags the incoming slot as V and the oldest zero
// of the run (still in the register) as a substitution start.
// Assumes the mode input only changes while reset is asserted.
module zs_lookahead
    import zs_pkg::*;
#(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_short,
    input  logic data_in,
    output sym_t tap_sym
);
    localparam int DEPTH = RUN_LONG;
    localparam int CW    = $clog2(RUN_LONG + 1);

    sym_t           shreg_q [DEPTH];
    logic [CW-1:0]  zrun_q;
    logic [CW-1:0]  run_len;
    logic           fire;
    logic           win_clear;

    assign run_len = mode_short ? CW'(RUN_SHORT) : CW'(RUN_LONG);
    assign fire    = !data_in && (zrun_q == run_len - 1'b1);

    // Count consecutive input zeros, restarting after each substitution.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun_q <= '0;
        else if (data_in || fire)
            zrun_q <= '0;
        else
            zrun_q <= zrun_q + 1'b1;
    end

    // Shift symbols toward the tap, tagging a completed run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                shreg_q[i] <= SYM_SPACE;
        end else begin
            shreg_q[0] <= fire ? SYM_VIOL : (data_in ? SYM_MARK : SYM_SPACE);
            for (int i = 1; i < DEPTH; i++)
                shreg_q[i] <= (fire && (i == int'(run_len) - 1)) ? SYM_SUBST
                                                                  : shreg_q[i-1];
        end
    end

    // Tap position depends on run length: one slot deeper for the long run.
    assign tap_sym = mode_short ? shreg_q[RUN_SHORT-1] : shreg_q[RUN_LONG-1];

    // Check helper: every stored slot belonging to the pending run is a plain zero.
    always_comb begin
        win_clear = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++)
            if ((i < int'(run_len) - 1) && (shreg_q[i] != SYM_SPACE))
                win_clear = 1'b0;
    end

    // R3 R4
    zrun_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q < run_len);

    // R3 R4 R5
    run_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> win_clear);

endmodule

// File: rtl/zs_passthru.sv
// Raw rail stage for bypass and remote loopback.
// Registers either the transmit rails or the received rails; the
// line register adds the second stage.
module zs_passthru (
    input  logic clk,
    input  logic rst_n,
    input  logic use_rx,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic raw_pos,
    output logic raw_neg
);
    // Capture the selected rail pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_pos <= 1'b0;
            raw_neg <= 1'b0;
        end else begin
            raw_pos <= use_rx ? rx_pos : tx_pos;
            raw_neg <= use_rx ? rx_neg : tx_neg;
        end
    end
endmodule

// File: rtl/zs_polarity.sv
// Polarity tracker and line output register.
// Resolves encoder symbols into signed marks (alternating marks, B or
// zero by mark-count parity, V at the previous polarity), produces the
// all-ones pattern, or forwards raw rails. Assumes the selector is
// already prioritised.
module zs_polarity
    import zs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  out_sel_t sel,
    input  sym_t     tap_sym,
    input  logic     raw_pos,
    input  logic     raw_neg,
    output logic     line_pos,
    output logic     line_neg
);
    logic last_pos_q, odd_q;
    logic nxt_p, nxt_n, nxt_last, nxt_odd;
    logic ones_prev_q;

    // Next line value and tracker update for the selected source.
    always_comb begin
        nxt_p    = 1'b0;
        nxt_n    = 1'b0;
        nxt_last = last_pos_q;
        nxt_odd  = odd_q;
        unique case (sel)
            OUT_LOOP, OUT_RAW: begin
                nxt_p = raw_pos;
                nxt_n = raw_neg;
            end
            OUT_ONES: begin
                nxt_p    = !last_pos_q;
                nxt_n    = last_pos_q;
                nxt_last = !last_pos_q;
            end
            default: begin
                unique case (tap_sym)
                    SYM_MARK: begin
                        nxt_p    = !last_pos_q;
                        nxt_n    = last_pos_q;
                        nxt_last = !last_pos_q;
                        nxt_odd  = !odd_q;
                    end
                    SYM_SUBST: begin
                        if (!odd_q) begin
                            nxt_p    = !last_pos_q;
                            nxt_n    = last_pos_q;
                            nxt_last = !last_pos_q;
                            nxt_odd  = 1'b1;
                        end
                    end
                    SYM_VIOL: begin
                        nxt_p   = last_pos_q;
                        nxt_n   = !last_pos_q;
                        nxt_odd = 1'b0;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    // Register line outputs and polarity state; last mark starts negative.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pos   <= 1'b0;
            line_neg   <= 1'b0;
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
        end else begin
            line_pos   <= nxt_p;
            line_neg   <= nxt_n;
            last_pos_q <= nxt_last;
            odd_q      <= nxt_odd;
        end
    end

    // Remember whether the previous output came from the all-ones source.
    always_ff @(posedge clk) begin
        if (!rst_n) ones_prev_q <= 1'b0;
        else        ones_prev_q <= (sel == OUT_ONES);
    end

    // R2 R8
    no_dual_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == OUT_ENC || sel == OUT_ONES) |=> !(line_pos && line_neg));

    // R8
    ones_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == OUT_ONES && ones_prev_q) |=>
            (line_pos == $past(line_neg)) && (line_neg == $past(line_pos))
            && (line_pos != line_neg));

    // R3 R4
    viol_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == OUT_ENC && tap_sym == SYM_VIOL) |=>
            (line_pos == $past(last_pos_q)) && (line_neg != line_pos));

endmodule

// File: rtl/zs_line_encoder.sv
// Top of the zero-substitution line encoder.
// Priority: remote loopback, then all-ones, then bypass, then encoder.
// Control and mode inputs are expected to be static during traffic.
module zs_line_encoder
    import zs_pkg::*;
#(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_b3zs,
    input  logic enc_bypass,
    input  logic all_ones,
    input  logic remote_loop,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic line_pos,
    output logic line_neg
);
    sym_t     tap_sym;
    out_sel_t sel;
    logic     raw_pos, raw_neg;

    // Fixed-priority choice of the line source.
    always_comb begin
        if (remote_loop)     sel = OUT_LOOP;
        else if (all_ones)   sel = OUT_ONES;
        else if (enc_bypass) sel = OUT_RAW;
        else                 sel = OUT_ENC;
    end

    zs_lookahead #(
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG)
    ) i_lookahead (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_short (sel_b3zs),
        .data_in    (tx_pos | tx_neg),
        .tap_sym    (tap_sym)
    );

    zs_passthru i_passthru (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_rx  (remote_loop),
        .tx_pos  (tx_pos),
        .tx_neg  (tx_neg),
        .rx_pos  (rx_pos),
        .rx_neg  (rx_neg),
        .raw_pos (raw_pos),
        .raw_neg (raw_neg)
    );

    zs_polarity i_polarity (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .tap_sym  (tap_sym),
        .raw_pos  (raw_pos),
        .raw_neg  (raw_neg),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

endmodule

// File: tb/test_zs_line_encoder.sv
module test_zs_line_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_LEN    = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_b3zs = 1'b1, enc_bypass = 1'b0, all_ones = 1'b0, remote_loop = 1'b0;
    logic tx_pos = 1'b0, tx_neg = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic line_pos, line_neg;

    int n_checks = 0;
    int n_fails  = 0;

    logic seq   [SEG_LEN];
    logic ap    [SEG_LEN];
    logic an    [SEG_LEN];
    int   expc  [SEG_LEN];   // 0 none, 1 positive mark, 2 negative mark

    always #(CLK_PERIOD/2) clk = ~clk;

    zs_line_encoder i_zs_line_encoder (
        .clk(clk), .rst_n(rst_n), .sel_b3zs(sel_b3zs), .enc_bypass(enc_bypass),
        .all_ones(all_ones), .remote_loop(remote_loop), .tx_pos(tx_pos),
        .tx_neg(tx_neg), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .line_pos(line_pos), .line_neg(line_neg));

    function automatic int code_of(input logic p, input logic n);
        return (p && n) ? 3 : (p ? 1 : (n ? 2 : 0));
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: line code actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Greedy reference: runs of n zeros replaced from their first zero.
    task automatic build_model(input logic b3);
        int n = b3 ? 3 : 4;
        bit last_pos = 1'b0;
        bit odd = 1'b0;
        int i = 0;
        while (i < SEG_LEN) begin
            if (seq[i]) begin
                last_pos = !last_pos; expc[i] = last_pos ? 1 : 2; odd = !odd; i++;
            end else begin
                bit run = (i + n <= SEG_LEN);
                for (int k = 0; k < n; k++)
                    if (i + k < SEG_LEN && seq[i+k]) run = 1'b0;
                if (run) begin
                    if (!odd) begin last_pos = !last_pos; expc[i] = last_pos ? 1 : 2; end
                    else expc[i] = 0;
                    for (int k = 1; k < n - 1; k++) expc[i+k] = 0;
                    expc[i+n-1] = last_pos ? 1 : 2;
                    odd = 1'b0;
                    i += n;
                end else begin
                    expc[i] = 0; i++;
                end
            end
        end
    endtask

    // Reset with controls applied; release at a falling edge.
    task automatic do_reset(input logic b3, input logic byp, input logic ones, input logic rl);
        rst_n = 1'b0; sel_b3zs = b3; enc_bypass = byp; all_ones = ones; remote_loop = rl;
        tx_pos = 1'b0; tx_neg = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", code_of(line_pos, line_neg), 0);
        rst_n = 1'b1;
    endtask

    // kind 0 sparse random, 1 all zeros, 2 one mark then zeros, 3 dense random
    task automatic fill_seq(input int kind);
        for (int i = 0; i < SEG_LEN; i++) begin
            case (kind)
                0: seq[i] = ($urandom % 100) < 30;
                1: seq[i] = 1'b0;
                2: seq[i] = (i == 0);
                default: seq[i] = ($urandom % 100) < 85;
            endcase
        end
    endtask

    task automatic run_encoder(input logic b3, input int kind, input string tag);
        int lat = b3 ? 4 : 5;
        fill_seq(kind);
        build_model(b3);
        do_reset(b3, 1'b0, 1'b0, 1'b0);
        for (int m = 0; m < SEG_LEN + lat; m++) begin
            if (m < SEG_LEN && seq[m]) begin
                // R10: mark on either rail or both
                case ($urandom % 3)
                    0: begin tx_pos = 1'b1; tx_neg = 1'b1; end
                    1: begin tx_pos = 1'b1; tx_neg = 1'b0; end
                    default: begin tx_pos = 1'b0; tx_neg = 1'b1; end
                endcase
            end else begin
                tx_pos = 1'b0; tx_neg = 1'b0;
            end
            @(negedge clk);
            if (m + 1 - lat >= 0 && m + 1 - lat < SEG_LEN - 4)
                check(tag, code_of(line_pos, line_neg), expc[m + 1 - lat]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R3 R5 R6 R10: three-zero mode, sparse data
        run_encoder(1'b1, 0, "R3 R5 R6 R10 sparse");
        // R4 R5 R6 R10: four-zero mode, sparse data
        run_encoder(1'b0, 0, "R4 R5 R6 R10 sparse");
        // R3 R5: back-to-back substitutions
        run_encoder(1'b1, 1, "R3 R5 all zeros");
        // R1 R4: single positive mark then a 000V, then B00V chains
        run_encoder(1'b0, 2, "R1 R4 R5 lead mark");
        // R2 R3: dense marks, mostly plain alternation
        run_encoder(1'b1, 3, "R2 R3 dense");
        run_encoder(1'b0, 3, "R2 R4 dense");
        run_encoder(1'b0, 1, "R4 R5 all zeros");

        // R7: bypass copies rails after two edges, no substitution
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < SEG_LEN; i++) begin
            ap[i] = ($urandom % 4) == 0; an[i] = ($urandom % 4) == 0;
        end
        for (int m = 0; m < SEG_LEN; m++) begin
            tx_pos = ap[m]; tx_neg = an[m];
            @(negedge clk);
            if (m - 1 >= 0) check("R7 bypass", code_of(line_pos, line_neg), code_of(ap[m-1], an[m-1]));
        end

        // R8: all-ones overrides bypass and ignores transmit data
        do_reset(1'b0, 1'b1, 1'b1, 1'b0);
        for (int m = 0; m < 64; m++) begin
            tx_pos = 1'($urandom); tx_neg = 1'($urandom);
            @(negedge clk);
            check("R8 all ones", code_of(line_pos, line_neg), ((m + 1) % 2 == 1) ? 1 : 2);
        end

        // R9: loopback overrides all-ones and ignores transmit rails
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < SEG_LEN; i++) begin
            ap[i] = 1'($urandom); an[i] = 1'($urandom);
        end
        for (int m = 0; m < SEG_LEN; m++) begin
            rx_pos = ap[m]; rx_neg = an[m];
            tx_pos = 1'($urandom); tx_neg = 1'($urandom);
            @(negedge clk);
            if (m - 1 >= 0) check("R9 loopback", code_of(line_pos, line_neg), code_of(ap[m-1], an[m-1]));
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule